// File: doc/BRIEF.md
# Load-Dependent Peak and Sample Scheduler

This block sits in the digital core of a primary-side regulated flyback controller. It receives a digital estimate of the output load, given as a fraction of full constant-current load. From that estimate it derives two codes. The first is the peak current-sense threshold that the cycle-by-cycle comparator uses. The second is the sample ratio, which sets how far into the secondary conduction interval the feedback voltage is captured for the constant-voltage loop. Each code follows a three-segment schedule: flat at light load, flat at heavy load, and a straight line between the two breakpoints.

The block also times each secondary conduction interval with a saturating counter. The duration measured in one switching cycle is multiplied by the current sample ratio, and the product gives the strobe delay for the next cycle. The strobe is a one-clock pulse that must land before conduction ends. When conduction finishes first, no strobe is issued and a missed-sample flag is raised for that cycle. Threshold and ratio codes are in millivolts and in percent. The load code is 8 bits, where 255 stands for 100 %.

Top module: `peak_sample_sched`

## Requirements
- R1: While reset is high, and on the first clock after it is released, peak_thr reads 180, sample_ratio reads 50, and sample_strobe and sample_miss are 0.
- R2: For a load code of 5 or lower, peak_thr is 180 and sample_ratio is 50.
- R3: For a load code of 102 or higher, peak_thr is 630 and sample_ratio is 80.
- R4: For a load code L with 5 < L < 102, peak_thr is 180 + floor(450*(L-5)/97) and sample_ratio is 50 + floor(30*(L-5)/97).
- R5: peak_thr and sample_ratio are registered and change on the first rising edge after load_lvl changes.
- R6: The conduction duration D is the number of rising edges from the edge that samples cond_start to the edge that samples cond_end. It saturates at 4095.
- R7: The strobe target is T = floor(Dprev*ratio/100), taken at the start edge, where Dprev is the last completed duration and ratio is sample_ratio at that edge. If 0 < T < D, sample_strobe is high for exactly one clock, the one following the edge T edges after the start edge.
- R8: If T > 0 and T >= D, no strobe is issued. sample_miss goes high from the end edge and stays high until the next cond_start edge clears it.
- R9: When T is 0, for example the first interval after reset, the interval produces neither a strobe nor a miss.
- R10: A cond_end pulse while no interval is open has no effect on outputs or on the stored duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_lvl | input | 8 | Load estimate, 255 = full constant-current load |
| cond_start | input | 1 | One-clock pulse at the start of secondary conduction |
| cond_end | input | 1 | One-clock pulse at the end of secondary conduction |
| peak_thr | output | 10 | Peak current-sense threshold in mV |
| sample_ratio | output | 7 | Sample point as a percentage of conduction time |
| sample_strobe | output | 1 | One-clock feedback sample strobe |
| sample_miss | output | 1 | Set when an interval ended before its strobe time |

## Verification
The schedule is walked across load codes on both flat segments, on both breakpoints, one code inside each breakpoint, and points mid-slope. This separates a wrong segment choice from wrong rounding of the interpolation. Conduction intervals are run with the target well inside the interval, one edge before the end, exactly at the end, and past the end, which pins down the strict boundary between strobe and miss. Further intervals cover the zero target after reset, a stray end pulse while idle, and an interval long enough to saturate the duration counter, checking that the duration of the previous cycle and not the current one sets the delay.

// File: rtl/psched_pkg.sv
package psched_pkg;

    localparam int unsigned PS_LOAD_W   = 8;
    localparam int unsigned PS_THR_W    = 10;
    localparam int unsigned PS_RATIO_W  = 7;
    localparam int unsigned PS_CNT_W    = 12;

    localparam int unsigned PS_LOAD_LO  = 5;
    localparam int unsigned PS_LOAD_HI  = 102;
    localparam int unsigned PS_THR_LO   = 180;
    localparam int unsigned PS_THR_HI   = 630;
    localparam int unsigned PS_RAT_LO   = 50;
    localparam int unsigned PS_RAT_HI   = 80;
    localparam int unsigned PS_PCT_FULL = 100;

    typedef struct packed {
        logic [PS_THR_W-1:0]   thr;
        logic [PS_RATIO_W-1:0] ratio;
    } lvl_codes_t;

    typedef enum logic [1:0] {
        SEG_LOW  = 2'd0,
        SEG_MID  = 2'd1,
        SEG_HIGH = 2'd2
    } seg_t;

    function automatic int unsigned lerp(input int unsigned x,
                                         input int unsigned x0,
                                         input int unsigned x1,
                                         input int unsigned y0,
                                         input int unsigned y1);
        return y0 + ((y1 - y0) * (x - x0)) / (x1 - x0);
    endfunction

endpackage

// File: rtl/psched_level_map.sv
module psched_level_map
    import psched_pkg::*;
#(
    parameter int unsigned LOAD_LO  = PS_LOAD_LO,
    parameter int unsigned LOAD_HI  = PS_LOAD_HI,
    parameter int unsigned THR_LO   = PS_THR_LO,
    parameter int unsigned THR_HI   = PS_THR_HI,
    parameter int unsigned RATIO_LO = PS_RAT_LO,
    parameter int unsigned RATIO_HI = PS_RAT_HI
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PS_LOAD_W-1:0] load_lvl,
    output lvl_codes_t           codes_q
);

    seg_t       seg;
    lvl_codes_t codes_n;

    always_comb begin
        if (load_lvl <= PS_LOAD_W'(LOAD_LO))
            seg = SEG_LOW;
        else if (load_lvl >= PS_LOAD_W'(LOAD_HI))
            seg = SEG_HIGH;
        else
            seg = SEG_MID;
    end

    always_comb begin
        case (seg)
            SEG_LOW: begin
                codes_n.thr   = PS_THR_W'(THR_LO);
                codes_n.ratio = PS_RATIO_W'(RATIO_LO);
            end
            SEG_HIGH: begin
                codes_n.thr   = PS_THR_W'(THR_HI);
                codes_n.ratio = PS_RATIO_W'(RATIO_HI);
            end
            default: begin
                codes_n.thr   = PS_THR_W'(lerp(32'(load_lvl), LOAD_LO, LOAD_HI,
                                               THR_LO, THR_HI));
                codes_n.ratio = PS_RATIO_W'(lerp(32'(load_lvl), LOAD_LO, LOAD_HI,
                                                 RATIO_LO, RATIO_HI));
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            codes_q.thr   <= PS_THR_W'(THR_LO);
            codes_q.ratio <= PS_RATIO_W'(RATIO_LO);
        end else begin
            codes_q <= codes_n;
        end
    end

endmodule

// File: rtl/psched_cond_timer.sv
module psched_cond_timer #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cond_start,
    input  logic             cond_end,
    output logic             active,
    output logic             end_hit,
    output logic [CNT_W-1:0] step,
    output logic [CNT_W-1:0] meas
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt;

    assign step    = (cnt == CNT_MAX) ? CNT_MAX : cnt + 1'b1;
    assign end_hit = active && cond_end && !cond_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            meas   <= '0;
        end else if (cond_start) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active) begin
            if (cond_end) begin
                active <= 1'b0;
                meas   <= step;
            end else begin
                cnt <= step;
            end
        end
    end

endmodule

// File: rtl/psched_strobe_gen.sv
module psched_strobe_gen #(
    parameter int unsigned CNT_W    = 12,
    parameter int unsigned RATIO_W  = 7,
    parameter int unsigned PCT_FULL = 100
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cond_start,
    input  logic               active,
    input  logic               end_hit,
    input  logic [CNT_W-1:0]   step,
    input  logic [CNT_W-1:0]   meas,
    input  logic [RATIO_W-1:0] ratio,
    output logic               strobe,
    output logic               miss
);

    localparam int unsigned PROD_W = CNT_W + RATIO_W;

    logic [PROD_W-1:0] prod;
    logic [CNT_W-1:0]  tgt_n;
    logic [CNT_W-1:0]  tgt;
    logic              done;

    assign prod  = PROD_W'(meas) * PROD_W'(ratio);
    assign tgt_n = CNT_W'(prod / PROD_W'(PCT_FULL));

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt    <= '0;
            done   <= 1'b0;
            strobe <= 1'b0;
            miss   <= 1'b0;
        end else if (cond_start) begin
            tgt    <= tgt_n;
            done   <= 1'b0;
            strobe <= 1'b0;
            miss   <= 1'b0;
        end else if (end_hit) begin
            strobe <= 1'b0;
            done   <= 1'b1;
            if (!done && tgt != '0)
                miss <= 1'b1;
        end else if (active && !done && tgt != '0 && step == tgt) begin
            strobe <= 1'b1;
            done   <= 1'b1;
        end else begin
            strobe <= 1'b0;
        end
    end

endmodule

// File: rtl/peak_sample_sched.sv
module peak_sample_sched
    import psched_pkg::*;
#(
    parameter int unsigned CNT_W    = PS_CNT_W,
    parameter int unsigned LOAD_LO  = PS_LOAD_LO,
    parameter int unsigned LOAD_HI  = PS_LOAD_HI,
    parameter int unsigned THR_LO   = PS_THR_LO,
    parameter int unsigned THR_HI   = PS_THR_HI,
    parameter int unsigned RATIO_LO = PS_RAT_LO,
    parameter int unsigned RATIO_HI = PS_RAT_HI,
    parameter int unsigned PCT_FULL = PS_PCT_FULL
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [PS_LOAD_W-1:0]  load_lvl,
    input  logic                  cond_start,
    input  logic                  cond_end,
    output logic [PS_THR_W-1:0]   peak_thr,
    output logic [PS_RATIO_W-1:0] sample_ratio,
    output logic                  sample_strobe,
    output logic                  sample_miss
);

    lvl_codes_t       codes;
    logic             active;
    logic             end_hit;
    logic [CNT_W-1:0] step;
    logic [CNT_W-1:0] meas;

    psched_level_map #(
        .LOAD_LO (LOAD_LO),
        .LOAD_HI (LOAD_HI),
        .THR_LO  (THR_LO),
        .THR_HI  (THR_HI),
        .RATIO_LO(RATIO_LO),
        .RATIO_HI(RATIO_HI)
    ) u_map (
        .clk     (clk),
        .rst     (rst),
        .load_lvl(load_lvl),
        .codes_q (codes)
    );

    psched_cond_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .cond_start(cond_start),
        .cond_end  (cond_end),
        .active    (active),
        .end_hit   (end_hit),
        .step      (step),
        .meas      (meas)
    );

    psched_strobe_gen #(
        .CNT_W   (CNT_W),
        .RATIO_W (PS_RATIO_W),
        .PCT_FULL(PCT_FULL)
    ) u_strobe (
        .clk       (clk),
        .rst       (rst),
        .cond_start(cond_start),
        .active    (active),
        .end_hit   (end_hit),
        .step      (step),
        .meas      (meas),
        .ratio     (codes.ratio),
        .strobe    (sample_strobe),
        .miss      (sample_miss)
    );

    assign peak_thr     = codes.thr;
    assign sample_ratio = codes.ratio;

endmodule

// File: rtl/psched_checker.sv
module psched_checker
    import psched_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic [PS_LOAD_W-1:0]  load_lvl,
    input logic                  cond_start,
    input logic [PS_THR_W-1:0]   peak_thr,
    input logic [PS_RATIO_W-1:0] sample_ratio,
    input logic                  sample_strobe,
    input logic                  sample_miss
);

    p_reset_vals_r1: assert property (@(posedge clk)
        rst |=> (peak_thr == PS_THR_W'(PS_THR_LO) && !sample_strobe && !sample_miss));

    p_low_seg_r2: assert property (@(posedge clk) disable iff (rst)
        (load_lvl <= PS_LOAD_W'(PS_LOAD_LO)) |=>
            (peak_thr == PS_THR_W'(PS_THR_LO) && sample_ratio == PS_RATIO_W'(PS_RAT_LO)));

    p_high_seg_r3: assert property (@(posedge clk) disable iff (rst)
        (load_lvl >= PS_LOAD_W'(PS_LOAD_HI)) |=>
            (peak_thr == PS_THR_W'(PS_THR_HI) && sample_ratio == PS_RATIO_W'(PS_RAT_HI)));

    p_thr_range_r4: assert property (@(posedge clk) disable iff (rst)
        (peak_thr >= PS_THR_W'(PS_THR_LO) && peak_thr <= PS_THR_W'(PS_THR_HI)));

    p_ratio_range_r4: assert property (@(posedge clk) disable iff (rst)
        (sample_ratio >= PS_RATIO_W'(PS_RAT_LO) && sample_ratio <= PS_RATIO_W'(PS_RAT_HI)));

    p_strobe_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        sample_strobe |=> !sample_strobe);

    p_strobe_not_missed_r8: assert property (@(posedge clk) disable iff (rst)
        !(sample_strobe && sample_miss));

    p_miss_cleared_r8: assert property (@(posedge clk) disable iff (rst)
        cond_start |=> !sample_miss);

endmodule

bind peak_sample_sched psched_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .load_lvl     (load_lvl),
    .cond_start   (cond_start),
    .peak_thr     (peak_thr),
    .sample_ratio (sample_ratio),
    .sample_strobe(sample_strobe),
    .sample_miss  (sample_miss)
);

// File: tb/peak_sample_sched_bench.sv
module peak_sample_sched_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] load_lvl = 8'd0;
    logic       cond_start = 1'b0;
    logic       cond_end = 1'b0;
    logic [9:0] peak_thr;
    logic [6:0] sample_ratio;
    logic       sample_strobe;
    logic       sample_miss;

    int n_checks = 0;
    int n_fail   = 0;
    int prev_meas = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    peak_sample_sched u_peak_sample_sched (
        .clk          (clk),
        .rst          (rst),
        .load_lvl     (load_lvl),
        .cond_start   (cond_start),
        .cond_end     (cond_end),
        .peak_thr     (peak_thr),
        .sample_ratio (sample_ratio),
        .sample_strobe(sample_strobe),
        .sample_miss  (sample_miss)
    );

    // load, expected threshold (mV), expected ratio (%)
    localparam int NVEC = 10;
    localparam int VEC [NVEC][3] = '{
        '{0,   180, 50},
        '{5,   180, 50},
        '{6,   184, 50},
        '{20,  249, 54},
        '{50,  388, 63},
        '{101, 625, 79},
        '{102, 630, 80},
        '{200, 630, 80},
        '{255, 630, 80},
        '{4,   180, 50}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_cond(input int len, input int ratio, input string req);
        int tgt;
        int nstrobe;
        int strobe_at;
        bit hit;
        bit expmiss;
        tgt       = (prev_meas * ratio) / 100;
        nstrobe   = 0;
        strobe_at = -1;
        hit       = (tgt != 0) && (tgt < len);
        expmiss   = (tgt != 0) && (tgt >= len);
        cond_start = 1'b1;
        @(negedge clk);
        cond_start = 1'b0;
        chk(sample_miss == 1'b0, "R8 miss cleared by start", int'(sample_miss), 0);
        for (int k = 1; k <= len; k++) begin
            if (k == len) cond_end = 1'b1;
            @(negedge clk);
            cond_end = 1'b0;
            if (sample_strobe) begin
                nstrobe++;
                strobe_at = k;
            end
        end
        chk(nstrobe == (hit ? 1 : 0), {req, " strobe count"}, nstrobe, hit ? 1 : 0);
        if (hit)
            chk(strobe_at == tgt, {req, " strobe position"}, strobe_at, tgt);
        chk(sample_miss == expmiss, {req, " miss flag"}, int'(sample_miss), int'(expmiss));
        repeat (3) @(negedge clk);
        chk(sample_miss == expmiss, "R8 miss held while idle", int'(sample_miss), int'(expmiss));
        prev_meas = (len > 4095) ? 4095 : len;
    endtask

    initial begin
        load_lvl = 8'd255;
        repeat (3) @(negedge clk);
        // R1: outputs held at reset values
        chk(peak_thr == 10'd180, "R1 thr in reset", int'(peak_thr), 180);
        chk(sample_ratio == 7'd50, "R1 ratio in reset", int'(sample_ratio), 50);
        chk(!sample_strobe && !sample_miss, "R1 strobe/miss in reset",
            int'({sample_strobe, sample_miss}), 0);
        load_lvl = 8'd0;
        rst = 1'b0;
        @(negedge clk);
        chk(peak_thr == 10'd180, "R1 thr after release", int'(peak_thr), 180);

        // Schedule table: R2, R3, R4 values, R5 one-edge latency
        for (int i = 0; i < NVEC; i++) begin
            int pthr;
            int prat;
            pthr = int'(peak_thr);
            prat = int'(sample_ratio);
            load_lvl = 8'(VEC[i][0]);
            #1;
            chk(int'(peak_thr) == pthr && int'(sample_ratio) == prat,
                "R5 no change before edge", int'(peak_thr), pthr);
            @(negedge clk);
            chk(int'(peak_thr) == VEC[i][1], "R2/R3/R4 threshold", int'(peak_thr), VEC[i][1]);
            chk(int'(sample_ratio) == VEC[i][2], "R2/R3/R4 ratio", int'(sample_ratio), VEC[i][2]);
        end

        // Conduction timing at 80 %
        load_lvl = 8'd255;
        repeat (2) @(negedge clk);
        run_cond(20, 80, "R9 zero target");
        run_cond(20, 80, "R7 target inside");
        run_cond(10, 80, "R8 target past end");

        // R10: stray end while idle
        cond_end = 1'b1;
        @(negedge clk);
        cond_end = 1'b0;
        @(negedge clk);
        chk(!sample_strobe, "R10 no strobe on stray end", int'(sample_strobe), 0);
        chk(sample_miss == 1'b1, "R10 miss unchanged", int'(sample_miss), 1);
        run_cond(25, 80, "R10 duration kept");

        load_lvl = 8'd0;
        repeat (2) @(negedge clk);
        run_cond(30, 50, "R7 ratio 50");
        run_cond(15, 50, "R8 target equals end");

        load_lvl = 8'd50;
        repeat (2) @(negedge clk);
        run_cond(10, 63, "R7 one before end");

        load_lvl = 8'd255;
        repeat (2) @(negedge clk);
        run_cond(4100, 80, "R6 long interval");
        run_cond(3300, 80, "R6 saturated duration");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule